// File: doc/BRIEF.md
# Programmable Waveform Bus Master

This block masters an external parallel bus with a protocol that software defines rather than logic. A small table of state vectors, loaded through a register-write port, describes one bus waveform: each vector sets the six control outputs, may wait until a chosen set of ready inputs reaches chosen levels, and may move one data word between the bus and a local FIFO while stepping the address output. The last vector of the table path ends one transaction.

A start pulse runs the waveform once per transaction for a loaded 32-bit count, with a live remaining-count output. When a vector needs the FIFO and the FIFO cannot supply a word (bus writes) or take one (bus reads), the engine holds that vector until it can, so data is never lost or invented. When the count is used up, the engine pulses a done flag and returns the control outputs to a programmed idle pattern. The data path can run 8 or 16 bits wide.

Top module: `wfm_engine`

## Requirements
- R1: After reset the engine is idle: busy, done, FIFO read and write enables and bus output enable are 0, the remaining count is 0 and the control outputs are 0.
- R2: A register write to address 0..7 loads that vector with bits [5:0] control levels, [11:6] ready mask, [17:12] ready polarity, [20:18] next index on match, [23:21] next index otherwise, [24] FIFO advance, [25] address increment, [26] data drive, [27] end of waveform; while busy the control outputs show the current vector's levels, and when idle they show the idle pattern from bits [5:0] of the register at address 9.
- R3: A vector matches when every ready input selected by its mask equals the matching polarity bit (an empty mask always matches); on a match the engine moves to the match index, otherwise to the other index, and no FIFO or address step occurs without a match.
- R4: With register 9 bit 7 set (FIFO to bus), a matching vector with FIFO advance presents the FIFO head on the bus data output and pulses the FIFO read enable; while the FIFO is empty it holds the vector and never reads.
- R5: With register 9 bit 7 clear (bus to FIFO), a matching vector with FIFO advance writes the bus input word into the FIFO; while the FIFO is full it holds the vector and never writes.
- R6: With register 9 bit 6 clear the bus is 8 bits wide: the upper byte of both the bus data output and the FIFO write data is 0; with it set all 16 bits pass.
- R7: At start the address output loads bits [8:0] of register 10; each matching step of a vector with address increment adds 1, wrapping from 511 to 0.
- R8: At start the remaining count loads register 8; each match of an end-of-waveform vector completes one transaction, subtracts 1 and restarts at vector 0.
- R9: When the final transaction completes, done is 1 for exactly one cycle with busy 0, remaining count 0 and the control outputs at the idle pattern.
- R10: A start with a loaded count of 0 raises done on the next cycle without entering the busy state or moving any data.
- R11: While busy, start pulses and register writes are ignored.
- R12: The bus output enable is 1 only while busy, in FIFO-to-bus direction, on a vector with the data-drive flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| start | input | 1 | Start pulse |
| busy | output | 1 | Waveform sequence running |
| done | output | 1 | One-cycle completion flag |
| xfer_left | output | 32 | Remaining transaction count |
| ctl_o | output | 6 | Control outputs |
| rdy_i | input | 6 | Ready inputs |
| adr_o | output | 9 | Address output |
| bus_dout | output | 16 | Data driven to the bus |
| bus_oe | output | 1 | Bus output enable |
| bus_din | input | 16 | Data read from the bus |
| fifo_rd_en | output | 1 | Pop from the source FIFO |
| fifo_rd_data | input | 16 | Source FIFO head word |
| fifo_empty | input | 1 | Source FIFO has no word |
| fifo_wr_en | output | 1 | Push into the sink FIFO |
| fifo_wr_data | output | 16 | Word pushed into the sink FIFO |
| fifo_full | input | 1 | Sink FIFO has no room |

## Verification
The assertions assume the FIFO flags are honest for the cycle in which they are sampled and that the ready inputs and bus data are stable around the clock edge; the bench drives all of them at the falling edge and models the source FIFO so the empty flag only clears when its pointer truly lags the available count. The count and address step properties assume no register write alters the live state mid-run, which the bench tries deliberately by writing the count register and pulsing start while busy, then proving through a reload-free rerun that the old count still applies.

// File: rtl/wfm_pkg.sv
package wfm_pkg;
  localparam int CTL_W = 6;
  localparam int RDY_W = 6;
  localparam int NVEC  = 8;
  localparam int IDX_W = $clog2(NVEC);
  localparam int REG_W = 32;
  localparam int RA_W  = 4;

  localparam logic [RA_W-1:0] RA_CNT = 4'd8;
  localparam logic [RA_W-1:0] RA_CFG = 4'd9;
  localparam logic [RA_W-1:0] RA_ADR = 4'd10;

  typedef struct packed {
    logic             last;
    logic             drive;
    logic             adr_inc;
    logic             fifo_adv;
    logic [IDX_W-1:0] nxt_else;
    logic [IDX_W-1:0] nxt_hit;
    logic [RDY_W-1:0] pol;
    logic [RDY_W-1:0] mask;
    logic [CTL_W-1:0] ctl;
  } wfm_vec_t;

  localparam int VEC_W = $bits(wfm_vec_t);
endpackage

// File: rtl/wfm_regs.sv
module wfm_regs
  import wfm_pkg::*;
#(
  parameter int ADR_W = 9,
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RA_W-1:0]   addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              lock,
  input  logic [IDX_W-1:0]  rd_idx,
  output wfm_vec_t          vec,
  output logic [CNT_W-1:0]  cnt,
  output logic [CTL_W-1:0]  idle_ctl,
  output logic              wide,
  output logic              dir_out,
  output logic [ADR_W-1:0]  start_adr
);
  localparam int CFG_W = CTL_W + 2;

  logic              wr_ok;
  logic [VEC_W-1:0]  tbl [NVEC];
  logic [CNT_W-1:0]  cnt_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [ADR_W-1:0]  adr_q;

  assign wr_ok = we & ~lock;

  for (genvar g = 0; g < NVEC; g++) begin : g_vec
    logic en;
    assign en = wr_ok & (addr == RA_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tbl[g] <= '0;
      else if (en) tbl[g] <= wdata[VEC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cfg_q <= '0;
      adr_q <= '0;
    end else begin
      if (wr_ok && addr == RA_CNT) cnt_q <= wdata[CNT_W-1:0];
      if (wr_ok && addr == RA_CFG) cfg_q <= wdata[CFG_W-1:0];
      if (wr_ok && addr == RA_ADR) adr_q <= wdata[ADR_W-1:0];
    end
  end

  assign vec       = wfm_vec_t'(tbl[rd_idx]);
  assign cnt       = cnt_q;
  assign idle_ctl  = cfg_q[CTL_W-1:0];
  assign wide      = cfg_q[CTL_W];
  assign dir_out   = cfg_q[CTL_W+1];
  assign start_adr = adr_q;

  AST_LOCK_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(cnt_q)); // R11
  AST_LOCK_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(cfg_q)); // R11
endmodule

// File: rtl/wfm_datapath.sv
module wfm_datapath
  import wfm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  wfm_vec_t          vec,
  input  logic              dir_out,
  input  logic              wide,
  input  logic [RDY_W-1:0]  rdy_i,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  input  logic [DATA_W-1:0] fifo_rd_data,
  input  logic [DATA_W-1:0] bus_din,
  output logic              hit,
  output logic              stall,
  output logic              fifo_rd_en,
  output logic              fifo_wr_en,
  output logic [DATA_W-1:0] fifo_wr_data,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe
);
  localparam int HALF = DATA_W / 2;

  logic want;

  function automatic logic [DATA_W-1:0] narrow(input logic w, input logic [DATA_W-1:0] d);
    return w ? d : {{(DATA_W-HALF){1'b0}}, d[HALF-1:0]};
  endfunction

  always_comb begin
    hit          = &(~vec.mask | ~(rdy_i ^ vec.pol));
    want         = busy & vec.fifo_adv & hit;
    stall        = want & (dir_out ? fifo_empty : fifo_full);
    fifo_rd_en   = want &  dir_out & ~fifo_empty;
    fifo_wr_en   = want & ~dir_out & ~fifo_full;
    fifo_wr_data = narrow(wide, bus_din);
    bus_dout     = narrow(wide, fifo_rd_data);
    bus_oe       = busy & vec.drive & dir_out;
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |-> !fifo_empty); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en |-> !fifo_full); // R5
  AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_rd_en && fifo_wr_en)); // R4
endmodule

// File: rtl/wfm_seq.sv
module wfm_seq
  import wfm_pkg::*;
#(
  parameter int ADR_W = 9,
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  cnt_load,
  input  logic [ADR_W-1:0]  start_adr,
  input  wfm_vec_t          vec,
  input  logic              hit,
  input  logic              stall,
  input  logic [CTL_W-1:0]  idle_ctl,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  idx,
  output logic [CNT_W-1:0]  xfer_left,
  output logic [ADR_W-1:0]  adr,
  output logic [CTL_W-1:0]  ctl_o
);
  logic              run_q, run_n;
  logic              done_q, done_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [CNT_W-1:0]  left_q, left_n;
  logic [ADR_W-1:0]  adr_q, adr_n;
  logic              step;

  always_comb begin
    run_n  = run_q;
    done_n = 1'b0;
    idx_n  = idx_q;
    left_n = left_q;
    adr_n  = adr_q;
    step   = run_q & ~stall;
    if (!run_q) begin
      if (start) begin
        if (cnt_load == '0) begin
          done_n = 1'b1;
        end else begin
          run_n  = 1'b1;
          idx_n  = '0;
          left_n = cnt_load;
          adr_n  = start_adr;
        end
      end
    end else if (step) begin
      if (hit) begin
        if (vec.adr_inc) adr_n = adr_q + 1'b1;
        if (vec.last) begin
          idx_n = '0;
          if (left_q <= CNT_W'(1)) begin
            run_n  = 1'b0;
            done_n = 1'b1;
            left_n = '0;
          end else begin
            left_n = left_q - 1'b1;
          end
        end else begin
          idx_n = vec.nxt_hit;
        end
      end else begin
        idx_n = vec.nxt_else;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      left_q <= '0;
      adr_q  <= '0;
    end else begin
      run_q  <= run_n;
      done_q <= done_n;
      idx_q  <= idx_n;
      left_q <= left_n;
      adr_q  <= adr_n;
    end
  end

  assign busy      = run_q;
  assign done      = done_q;
  assign idx       = idx_q;
  assign xfer_left = left_q;
  assign adr       = adr_q;
  assign ctl_o     = run_q ? vec.ctl : idle_ctl;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (xfer_left == $past(xfer_left) || xfer_left == $past(xfer_left) - 1'b1)); // R8
  AST_ADR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (adr == $past(adr) || adr == $past(adr) + 1'b1)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && xfer_left == '0)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

// File: rtl/wfm_engine.sv
module wfm_engine
  import wfm_pkg::*;
#(
  parameter int ADR_W  = 9,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [RA_W-1:0]   cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  xfer_left,
  output logic [CTL_W-1:0]  ctl_o,
  input  logic [RDY_W-1:0]  rdy_i,
  output logic [ADR_W-1:0]  adr_o,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              fifo_rd_en,
  input  logic [DATA_W-1:0] fifo_rd_data,
  input  logic              fifo_empty,
  output logic              fifo_wr_en,
  output logic [DATA_W-1:0] fifo_wr_data,
  input  logic              fifo_full
);
  wfm_vec_t          vec;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  cnt;
  logic [CTL_W-1:0]  idle_ctl;
  logic              wide, dir_out, hit, stall;
  logic [ADR_W-1:0]  start_adr;

  wfm_regs #(.ADR_W(ADR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .lock(busy), .rd_idx(idx), .vec(vec), .cnt(cnt), .idle_ctl(idle_ctl),
    .wide(wide), .dir_out(dir_out), .start_adr(start_adr)
  );

  wfm_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .busy(busy), .vec(vec), .dir_out(dir_out),
    .wide(wide), .rdy_i(rdy_i), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .fifo_rd_data(fifo_rd_data), .bus_din(bus_din), .hit(hit), .stall(stall),
    .fifo_rd_en(fifo_rd_en), .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
    .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  wfm_seq #(.ADR_W(ADR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt_load(cnt), .start_adr(start_adr),
    .vec(vec), .hit(hit), .stall(stall), .idle_ctl(idle_ctl), .busy(busy),
    .done(done), .idx(idx), .xfer_left(xfer_left), .adr(adr_o), .ctl_o(ctl_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fifo_rd_en && !fifo_wr_en && !bus_oe)); // R12
endmodule

// File: tb/tb_wfm_engine.sv
`timescale 1ns/1ps
module tb_wfm_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        start;
  logic        busy, done, bus_oe, fifo_rd_en, fifo_wr_en;
  logic [31:0] xfer_left;
  logic [5:0]  ctl_o, rdy_i;
  logic [8:0]  adr_o;
  logic [15:0] bus_dout, bus_din, fifo_rd_data, fifo_wr_data;
  logic        fifo_empty, fifo_full;

  int checks = 0;
  int fails  = 0;
  int rd_ptr = 0;
  int src_avail = 0;
  int cycles = 0;
  logic [24:0] exp_q [$];

  always #2.5 clk = ~clk;

  wfm_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .start(start), .busy(busy), .done(done), .xfer_left(xfer_left), .ctl_o(ctl_o),
    .rdy_i(rdy_i), .adr_o(adr_o), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din),
    .fifo_rd_en(fifo_rd_en), .fifo_rd_data(fifo_rd_data), .fifo_empty(fifo_empty),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data), .fifo_full(fifo_full)
  );

  function automatic logic [15:0] src_word(input int p);
    return 16'hA000 ^ 16'(p * 311);
  endfunction

  function automatic logic [15:0] din_of(input logic [8:0] a);
    return {a[7:0] ^ 8'hC3, a[7:0] + 8'h11};
  endfunction

  function automatic logic [31:0] vword(input logic [5:0] c, input logic [5:0] m, input logic [5:0] p,
                                         input logic [2:0] nh, input logic [2:0] ne,
                                         input logic fa, input logic ai, input logic dr, input logic ls);
    return {4'h0, ls, dr, ai, fa, ne, nh, p, m, c};
  endfunction

  assign fifo_rd_data = src_word(rd_ptr);
  assign fifo_empty   = (rd_ptr >= src_avail);
  assign bus_din      = din_of(adr_o);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (fifo_rd_en) rd_ptr <= rd_ptr + 1;
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected items as the design moves data
  always @(negedge clk) begin
    if (rst_n && (fifo_rd_en || fifo_wr_en)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected data move", {23'h0, adr_o}, 32'h0);
      end else begin
        logic [24:0] e;
        e = exp_q.pop_front();
        check(adr_o == e[24:16], "R7 address", {23'h0, adr_o}, {23'h0, e[24:16]});
        if (fifo_rd_en) begin
          check(bus_dout == e[15:0], "R4 R6 bus data out", {16'h0, bus_dout}, {16'h0, e[15:0]});
          check(bus_oe, "R12 drive on output", {31'h0, bus_oe}, 32'h1);
        end else begin
          check(fifo_wr_data == e[15:0], "R5 R6 fifo data in", {16'h0, fifo_wr_data}, {16'h0, e[15:0]});
          check(!bus_oe && !fifo_full, "R12 R5 no drive/full on input", {30'h0, bus_oe, fifo_full}, 32'h0);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cycles > 100000) begin
      check(1'b0, "watchdog", cycles, 32'd100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(done, req, {31'h0, done}, 32'h1);
  endtask

  task automatic push_out(input int n, input logic [8:0] a0, input logic w16);
    for (int i = 0; i < n; i++) begin
      logic [15:0] d;
      d = src_word(rd_ptr + i);
      if (!w16) d[15:8] = 8'h0;
      exp_q.push_back({a0 + 9'(i), d});
    end
  endtask

  task automatic push_in(input int n, input logic [8:0] a0, input logic w16);
    for (int i = 0; i < n; i++) begin
      logic [15:0] d;
      d = din_of(a0 + 9'(i));
      if (!w16) d[15:8] = 8'h0;
      exp_q.push_back({a0 + 9'(i), d});
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; start = 1'b0;
    rdy_i = 6'b000001; fifo_full = 1'b0; src_avail = 1000;
    repeat (3) @(negedge clk);
    check(!busy && !done && xfer_left == 0 && ctl_o == 0 && !fifo_rd_en && !fifo_wr_en && !bus_oe,
          "R1 reset state", {busy, done, ctl_o}, 32'h0);
    rst_n = 1'b1;

    // program: wait rdy0=1 & rdy2=0, move one word, end
    cfg_write(4'd0, vword(6'h01, 6'b000101, 6'b000001, 3'd1, 3'd0, 0, 0, 0, 0));
    cfg_write(4'd1, vword(6'h03, 6'h00, 6'h00, 3'd2, 3'd2, 1, 1, 1, 0));
    cfg_write(4'd2, vword(6'h22, 6'h00, 6'h00, 3'd0, 3'd0, 0, 0, 0, 1));
    cfg_write(4'd9, 32'h0000_00EA);   // idle 2A, wide, FIFO to bus
    cfg_write(4'd10, 32'h0000_01FE);
    cfg_write(4'd8, 32'd5);
    check(ctl_o == 6'h2A, "R2 idle pattern", {26'h0, ctl_o}, 32'h2A);

    // R7 wrap, R4 outbound, R11 writes/start while busy
    push_out(5, 9'h1FE, 1'b1);
    pulse_start;
    check(busy && xfer_left == 5, "R8 count loaded", xfer_left, 32'd5);
    check(ctl_o == 6'h01, "R2 vector levels", {26'h0, ctl_o}, 32'h01);
    cfg_write(4'd8, 32'd9);
    pulse_start;
    wait_done("R9 done raised");
    check(!busy && ctl_o == 6'h2A && xfer_left == 0, "R9 idle after done", {26'h0, ctl_o}, 32'h2A);
    @(negedge clk);
    check(!done, "R9 done one cycle", {31'h0, done}, 32'h0);
    check(exp_q.size() == 0, "R8 all transactions", exp_q.size(), 32'h0);

    // rerun without reload: count must still be 5 (R11)
    push_out(5, 9'h1FE, 1'b1);
    pulse_start;
    check(xfer_left == 5, "R11 count write ignored while busy", xfer_left, 32'd5);
    wait_done("R11 rerun done");
    check(exp_q.size() == 0, "R11 rerun length", exp_q.size(), 32'h0);

    // R3 ready wait: rdy2 high blocks
    cfg_write(4'd8, 32'd2);
    cfg_write(4'd10, 32'h0000_0010);
    rdy_i = 6'b000101;
    push_out(2, 9'h010, 1'b1);
    begin
      int p0;
      p0 = rd_ptr;
      pulse_start;
      repeat (6) @(negedge clk);
      check(busy && ctl_o == 6'h01 && rd_ptr == p0 && adr_o == 9'h010, "R3 wait on ready mismatch",
            {26'h0, ctl_o}, 32'h01);
    end
    rdy_i = 6'b000001;
    wait_done("R3 done after match");

    // R4 stall on empty
    cfg_write(4'd8, 32'd4);
    push_out(4, 9'h010, 1'b1);
    src_avail = rd_ptr + 2;
    pulse_start;
    repeat (15) @(negedge clk);
    check(busy && ctl_o == 6'h03 && xfer_left == 2, "R4 stall on empty", xfer_left, 32'd2);
    src_avail = 1000;
    wait_done("R4 done after refill");
    check(exp_q.size() == 0, "R4 all words", exp_q.size(), 32'h0);

    // R6 8-bit outbound
    cfg_write(4'd9, 32'h0000_00AA);
    cfg_write(4'd8, 32'd3);
    push_out(3, 9'h010, 1'b0);
    pulse_start;
    wait_done("R6 narrow out done");

    // R5 inbound 8-bit with full throttling, R12 no drive
    cfg_write(4'd9, 32'h0000_002A);
    cfg_write(4'd8, 32'd6);
    cfg_write(4'd10, 32'h0000_0100);
    push_in(6, 9'h100, 1'b0);
    pulse_start;
    repeat (4) @(negedge clk);
    fifo_full = 1'b1;
    repeat (3) @(negedge clk);
    begin
      logic [31:0] l0;
      l0 = xfer_left;
      repeat (8) @(negedge clk);
      check(busy && xfer_left == l0 && !fifo_wr_en, "R5 stall on full", xfer_left, l0);
    end
    fifo_full = 1'b0;
    wait_done("R5 inbound done");
    check(exp_q.size() == 0, "R5 all words", exp_q.size(), 32'h0);

    // R6 16-bit inbound
    cfg_write(4'd9, 32'h0000_006A);
    cfg_write(4'd8, 32'd2);
    push_in(2, 9'h100, 1'b1);
    pulse_start;
    wait_done("R6 wide in done");

    // R10 zero count
    cfg_write(4'd8, 32'd0);
    begin
      int p0;
      p0 = rd_ptr;
      pulse_start;
      check(done && !busy, "R10 zero count done", {30'h0, done, busy}, 32'h2);
      @(negedge clk);
      check(!busy && rd_ptr == p0 && ctl_o == 6'h2A, "R10 no waveform", {26'h0, ctl_o}, 32'h2A);
    end

    check(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule